// File: doc/BRIEF.md
# Addressed Command Frame Parser

This block sits behind a UART byte receiver on a shared RS-485 bus. It consumes a stream of received bytes and groups them into fixed four-byte frames. Each frame carries an address, a command, a high data byte and a low data byte. The parser keeps a frame only when its address is the node's own address or the broadcast address. When such a frame carries the set-outputs command, the parser presents a 16-bit word on its data output together with a single-cycle update strobe.

Frames addressed to other nodes are not decoded. The parser counts off their remaining three bytes and then waits for the next address byte, so it stays aligned to frame boundaries on a busy bus. The node only listens, so the transceiver direction line is held in receive mode at all times.

Top module: `frame_cmd_parser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `upd_strobe` is 0, `upd_data` is 0 and the parser waits for an address byte.
- R2: Inside a frame the byte order is address, command, data high, data low. The data high byte drives `upd_data[15:8]` and the data low byte drives `upd_data[7:0]`.
- R3: A frame whose address byte equals the parameter `NODE_ADDR` (default 0x01) is decoded.
- R4: A frame whose address byte is 0xFF (broadcast, all ones) is decoded, whatever the value of `NODE_ADDR`.
- R5: After an address byte that matches neither, exactly the next 3 accepted bytes are discarded, whatever their values, including 0x01 and 0xFF. The byte after them is treated as an address byte.
- R6: Command 0x01 (set outputs) raises `upd_strobe` for exactly one cycle, in the cycle after the data low byte is accepted. `upd_data` shows the new word in that same cycle.
- R7: Any other command still consumes its two data bytes and then returns to waiting for an address. It produces no strobe and leaves `upd_data` unchanged.
- R8: `bus_drv_en` is 0 in every cycle, which selects receive mode on the transceiver.
- R9: A byte is accepted only in a cycle where `rx_valid` is 1. Idle cycles between bytes, of any length, do not change how the stream is parsed.
- R10: `upd_data` holds its value in every cycle in which `upd_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte from the UART |
| rx_valid | input | 1 | One-cycle strobe marking a new byte on `rx_byte` |
| upd_data | output | 16 | Last word delivered by a set-outputs command |
| upd_strobe | output | 1 | One-cycle pulse when `upd_data` takes a new word |
| bus_drv_en | output | 1 | Transceiver driver enable, held low (receive) |

## Verification
The assertions check on every cycle that the skip counter is never zero while bytes are being skipped, and that the parse phase does not move in a cycle without a byte. They also check that a strobe follows only the acceptance of a data low byte, lasts a single cycle, and that the output word changes only together with a strobe. Whether the parser stays aligned to frame boundaries is shown only by the bench's scenarios. These mix own-address, broadcast, foreign and unknown-command frames back to back and with gaps, and include foreign payloads that contain address-like bytes. The bench compares each cycle against a behavioural model running over a long pseudo-random stream.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

   typedef enum logic [2:0] {
      PH_ADDR = 3'd0,
      PH_SKIP = 3'd1,
      PH_CMD  = 3'd2,
      PH_DHI  = 3'd3,
      PH_DLO  = 3'd4
   } cfp_phase_e;

endpackage

// File: rtl/cfp_addr_match.sv
module cfp_addr_match #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned NODE_ADDR = 1
) (
   input  logic [BYTE_W-1:0] byte_in,
   output logic              hit
);
   localparam logic [BYTE_W-1:0] NODE_L  = BYTE_W'(NODE_ADDR);
   localparam logic [BYTE_W-1:0] BCAST_L = '1;

   generate
      if (NODE_L == BCAST_L) begin : g_single
         // node address coincides with broadcast: one comparator suffices
         assign hit = (byte_in == BCAST_L);
      end else begin : g_dual
         assign hit = (byte_in == NODE_L) || (byte_in == BCAST_L);
      end
   endgenerate
endmodule

// File: rtl/cfp_frame_seq.sv
module cfp_frame_seq
   import cfp_pkg::*;
#(
   parameter int unsigned SKIP_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic addr_hit,
   output logic take_cmd,
   output logic take_hi,
   output logic take_lo
);
   localparam int unsigned CNT_W = $clog2(SKIP_LEN + 1);
   localparam logic [CNT_W-1:0] SKIP_L = CNT_W'(SKIP_LEN);
   localparam logic [CNT_W-1:0] ONE_L  = CNT_W'(1);

   cfp_phase_e       phase, phase_nx;
   logic [CNT_W-1:0] skip_cnt, skip_cnt_nx;

   generate
      if (SKIP_LEN < 1) begin : g_bad_skip
         $error("SKIP_LEN must be at least 1");
      end
   endgenerate

   assign take_cmd = valid && (phase == PH_CMD);
   assign take_hi  = valid && (phase == PH_DHI);
   assign take_lo  = valid && (phase == PH_DLO);

   always_comb begin
      phase_nx    = phase;
      skip_cnt_nx = skip_cnt;
      if (valid) begin
         unique case (phase)
            PH_ADDR: begin
               if (addr_hit) begin
                  phase_nx = PH_CMD;
               end else begin
                  phase_nx    = PH_SKIP;
                  skip_cnt_nx = SKIP_L;
               end
            end
            PH_SKIP: begin
               skip_cnt_nx = skip_cnt - ONE_L;
               if (skip_cnt == ONE_L) phase_nx = PH_ADDR;
            end
            PH_CMD:  phase_nx = PH_DHI;
            PH_DHI:  phase_nx = PH_DLO;
            PH_DLO:  phase_nx = PH_ADDR;
            default: phase_nx = PH_ADDR;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_ADDR;
         skip_cnt <= '0;
      end else begin
         phase    <= phase_nx;
         skip_cnt <= skip_cnt_nx;
      end
   end

   // R5
   skip_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP) |-> (skip_cnt != '0));

   // R5
   skip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_cnt <= SKIP_L);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> $stable(phase) && $stable(skip_cnt));
endmodule

// File: rtl/cfp_word_build.sv
module cfp_word_build #(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned SET_CMD = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BYTE_W-1:0]   byte_in,
   input  logic                take_cmd,
   input  logic                take_hi,
   input  logic                take_lo,
   output logic [2*BYTE_W-1:0] word_out,
   output logic                word_stb
);
   localparam logic [BYTE_W-1:0] SET_L = BYTE_W'(SET_CMD);

   logic              is_set;
   logic [BYTE_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_set   <= 1'b0;
         hi_q     <= '0;
         word_out <= '0;
         word_stb <= 1'b0;
      end else begin
         word_stb <= 1'b0;
         if (take_cmd) is_set <= (byte_in == SET_L);
         if (take_hi)  hi_q   <= byte_in;
         if (take_lo && is_set) begin
            word_out <= {hi_q, byte_in};
            word_stb <= 1'b1;
         end
      end
   end

   // R6
   stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |-> $past(take_lo));

   // R6
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> !word_stb);

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_stb |-> $stable(word_out));
endmodule

// File: rtl/frame_cmd_parser.sv
module frame_cmd_parser #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned NODE_ADDR = 1,
   parameter int unsigned SET_CMD   = 1,
   parameter int unsigned SKIP_LEN  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BYTE_W-1:0]   rx_byte,
   input  logic                rx_valid,
   output logic [2*BYTE_W-1:0] upd_data,
   output logic                upd_strobe,
   output logic                bus_drv_en
);
   logic hit, take_cmd, take_hi, take_lo;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("BYTE_W must be at least 2");
      end
      if (NODE_ADDR >= (1 << BYTE_W)) begin : g_bad_addr
         $error("NODE_ADDR does not fit in BYTE_W bits");
      end
   endgenerate

   assign bus_drv_en = 1'b0;

   cfp_addr_match #(.BYTE_W(BYTE_W), .NODE_ADDR(NODE_ADDR)) u_match (
      .byte_in (rx_byte),
      .hit     (hit)
   );

   cfp_frame_seq #(.SKIP_LEN(SKIP_LEN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (rx_valid),
      .addr_hit (hit),
      .take_cmd (take_cmd),
      .take_hi  (take_hi),
      .take_lo  (take_lo)
   );

   cfp_word_build #(.BYTE_W(BYTE_W), .SET_CMD(SET_CMD)) u_build (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_in  (rx_byte),
      .take_cmd (take_cmd),
      .take_hi  (take_hi),
      .take_lo  (take_lo),
      .word_out (upd_data),
      .word_stb (upd_strobe)
   );

   // R7
   take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({take_cmd, take_hi, take_lo}));
endmodule

// File: tb/frame_cmd_parser_test.sv
`timescale 1ns/1ps
module frame_cmd_parser_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        rx_valid = 1'b0;
   logic [15:0] upd_data;
   logic        upd_strobe;
   logic        bus_drv_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   frame_cmd_parser uut (
      .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
      .upd_data(upd_data), .upd_strobe(upd_strobe), .bus_drv_en(bus_drv_en)
   );

   // behavioural reference: position in frame, bytes left to skip
   int          m_pos;     // 0 addr, 1 cmd, 2 hi, 3 lo, 9 skipping
   int          m_left;
   bit          m_set;
   logic [7:0]  m_hi;
   logic [15:0] m_data;
   bit          m_stb;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_left = 0; m_set = 0; m_hi = 0; m_data = 0; m_stb = 0;
      end else begin
         m_stb = 0;
         if (rx_valid) begin
            if (m_pos == 9) begin
               m_left = m_left - 1;
               if (m_left == 0) m_pos = 0;
            end else if (m_pos == 0) begin
               if (rx_byte == 8'h01 || rx_byte == 8'hFF) m_pos = 1;
               else begin m_pos = 9; m_left = 3; end
            end else if (m_pos == 1) begin
               m_set = (rx_byte == 8'h01); m_pos = 2;
            end else if (m_pos == 2) begin
               m_hi = rx_byte; m_pos = 3;
            end else begin
               if (m_set) begin m_data = {m_hi, rx_byte}; m_stb = 1; end
               m_pos = 0;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         check(upd_strobe == m_stb, "R6/R7 strobe vs model", 32'(upd_strobe), 32'(m_stb));
         check(upd_data == m_data, "R2/R10 data vs model", 32'(upd_data), 32'(m_data));
         check(bus_drv_en == 1'b0, "R8 drive enable", 32'(bus_drv_en), 32'd0);
      end
   end

   task automatic put(input logic [7:0] b);
      rx_valid = 1'b1; rx_byte = b;
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic frame(input logic [7:0] a, input logic [7:0] c,
                        input logic [7:0] h, input logic [7:0] l);
      put(a); put(c); put(h); put(l);
   endtask

   initial begin : watchdog
      #(5ns * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      idle(3);
      // R1: reset state
      check(upd_strobe == 0, "R1 strobe in reset", 32'(upd_strobe), 0);
      check(upd_data == 0, "R1 data in reset", 32'(upd_data), 0);
      rst_n = 1'b1;
      idle(1);
      check(upd_strobe == 0 && upd_data == 0, "R1 after reset", 32'(upd_data), 0);

      // R3 and R2: own address set-outputs
      frame(8'h01, 8'h01, 8'h12, 8'h34);
      check(upd_strobe == 1, "R6 strobe after low byte", 32'(upd_strobe), 1);
      check(upd_data == 16'h1234, "R2 R3 own frame word", 32'(upd_data), 32'h1234);
      idle(1);
      check(upd_strobe == 0, "R6 single-cycle strobe", 32'(upd_strobe), 0);

      // R4: broadcast, back to back with foreign frame whose payload looks like addresses (R5)
      frame(8'hFF, 8'h01, 8'hAB, 8'hCD);
      check(upd_data == 16'hABCD, "R4 broadcast word", 32'(upd_data), 32'hABCD);
      frame(8'h05, 8'h01, 8'hFF, 8'h01);
      check(upd_strobe == 0 && upd_data == 16'hABCD, "R5 foreign frame ignored",
            32'(upd_data), 32'hABCD);
      frame(8'h01, 8'h01, 8'h0F, 8'h0F);
      check(upd_data == 16'h0F0F, "R5 resync after skip", 32'(upd_data), 32'h0F0F);

      // R7: unknown command consumes data, no update
      frame(8'h01, 8'h02, 8'h01, 8'hFF);
      check(upd_strobe == 0 && upd_data == 16'h0F0F, "R7 unknown command",
            32'(upd_data), 32'h0F0F);
      frame(8'hFF, 8'h01, 8'h55, 8'hAA);
      check(upd_data == 16'h55AA, "R7 resync after unknown", 32'(upd_data), 32'h55AA);

      // R9: gaps inside frames
      put(8'h01); idle(4); put(8'h01); idle(1); put(8'hC3); idle(7); put(8'h3C);
      check(upd_strobe == 1 && upd_data == 16'hC33C, "R9 gapped frame",
            32'(upd_data), 32'hC33C);
      put(8'h07); idle(3); put(8'h01); put(8'h01); idle(2); put(8'h01);
      idle(5);
      check(upd_data == 16'hC33C, "R9 R10 gapped foreign frame held",
            32'(upd_data), 32'hC33C);

      // pseudo-random mixed stream against the model
      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] b;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (lfsr[2:0])
            3'd0, 3'd1: b = 8'h01;
            3'd2:       b = 8'hFF;
            default:    b = lfsr[15:8];
         endcase
         if (lfsr[3]) idle(1);
         put(b);
      end
      idle(4);
      check(bus_drv_en == 0, "R8 drive enable after stream", 32'(bus_drv_en), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule